// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block drives and samples 32 general-purpose lines, grouped as four 8-bit ports. Software reaches it through a flat 32-bit register interface with a byte address. Each line has a direction flag and an output value. Reading the data register returns the driven value on output lines and the synchronised pin level on input lines.

Every line can watch its synchronised input for a rising edge, a falling edge or both. A 2-bit mode code per line picks the edge and also enables the line, and code 0 leaves the line masked. A detected edge latches a pending flag in a status register, and software clears that flag by writing a 1 to it. Each CPU has its own enable mask. A CPU's interrupt output is high while any pending line is also set in that CPU's mask.

The parameter `REVERSED_ORDER` selects how ports are packed into register words. The mapping is the same for reads and for writes.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads zero and `gpio_oe`, `gpio_out` and `cpu_irq` are all zero.
- R2: The direction register is at offset 0x08 and the output register at 0x0C. Line L is driven (`gpio_oe[L]`=1) when its direction flag is 1 and is an input when the flag is 0. `gpio_out[L]` carries its output flag. In the 1-bit registers, line L sits at word bit 8*(3-L/8)+L%8 when `REVERSED_ORDER`=0, and at word bit L when it is 1.
- R3: A read of offset 0x0C returns the output flag for lines set as outputs, and the input pin level for lines set as inputs. The pin level is taken after a two-stage synchroniser.
- R4: Mode code 0 disables a line, 1 selects the falling edge, 2 the rising edge and 3 both edges. An edge sets the line's status flag only if the code enables that edge.
- R5: The mode codes occupy offset 0x14 (low word) and 0x18 (high word) of a 64-bit pair. Line L's field starts at bit 2*(8*((L/8) XOR 1)+L%8) when `REVERSED_ORDER`=0, and at bit 2*L when it is 1.
- R6: The status register is at offset 0x10, with the same bit layout as R2. Writing 1 to a bit clears that flag. Writing 0 leaves the flag unchanged.
- R7: If an edge and a clearing write reach the same status flag in the same cycle, the flag ends up set.
- R8: An input change sets its status flag on the third rising clock edge after the change.
- R9: CPU c has a mask at offset 0x40+4*c, with the same bit layout as R2. `cpu_irq[c]` is the OR over all lines of (status AND mask c).
- R10: Every other offset, including 0x00, 0x04, 0x1C and mask offsets beyond `NUM_CPUS`, reads zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, committed at the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_in | input | 32 | Pin levels, one per line |
| gpio_out | output | 32 | Output values, one per line |
| gpio_oe | output | 32 | Output enables, one per line |
| cpu_irq | output | NUM_CPUS | Level interrupt, one per CPU |

## Verification
The hardest case to reach from the ports is an edge landing on a status flag in exactly the cycle that a clearing write commits. The stimulus counts the synchroniser stages and starts the write two cycles after the pin change, so both arrive on the same clock edge. A sweep over every line and every mode code is run on a normal-order and a reversed-order instance side by side. It shows that each mode field and each mask bit reach only the line they belong to.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int PORT_BITS = 8;
  localparam int PORTS     = 4;
  localparam int LINES     = PORT_BITS * PORTS;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FALL = 2'd1,
    MODE_RISE = 2'd2,
    MODE_BOTH = 2'd3
  } edge_mode_e;

  localparam int OFS_DIR      = 'h08;
  localparam int OFS_DATA     = 'h0C;
  localparam int OFS_STAT     = 'h10;
  localparam int OFS_MODE_LO  = 'h14;
  localparam int OFS_MODE_HI  = 'h18;
  localparam int OFS_CPU_BASE = 'h40;

  // Maps line order to word order for 1-bit registers; the map is its own inverse.
  function automatic logic [LINES-1:0] swz_flags(input logic [LINES-1:0] v, input bit rev);
    logic [LINES-1:0] r;
    r = '0;
    for (int l = 0; l < LINES; l++) begin
      r[rev ? l : PORT_BITS*(PORTS-1-l/PORT_BITS) + l%PORT_BITS] = v[l];
    end
    return r;
  endfunction

  // Maps line order to the packed mode pair; also its own inverse.
  function automatic logic [2*LINES-1:0] swz_mode(input logic [2*LINES-1:0] v, input bit rev);
    logic [2*LINES-1:0] r;
    r = '0;
    for (int l = 0; l < LINES; l++) begin
      r[2*(rev ? l : PORT_BITS*((l/PORT_BITS) ^ 1) + l%PORT_BITS) +: 2] = v[2*l +: 2];
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINES-1:0]     pin_i,
  input  logic [2*LINES-1:0]   mode_i,
  output logic [LINES-1:0]     level_o,
  output logic [LINES-1:0]     event_o
);
  logic [SYNC_STAGES-1:0][LINES-1:0] stg_q;
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= level_o;
    end
  end

  assign level_o = stg_q[SYNC_STAGES-1];
  assign rise    = level_o & ~prev_q;
  assign fall    = ~level_o & prev_q;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    edge_mode_e m;
    assign m = edge_mode_e'(mode_i[2*l +: 2]);
    assign event_o[l] = ((m == MODE_RISE || m == MODE_BOTH) && rise[l]) ||
                        ((m == MODE_FALL || m == MODE_BOTH) && fall[l]);
  end

  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_o & ~(level_o ^ $past(level_o))) == '0)); // R8
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_edge_pkg::*;
#(
  parameter int NUM_CPUS = 2
) (
  input  logic [LINES-1:0]               stat_i,
  input  logic [NUM_CPUS-1:0][LINES-1:0] en_i,
  output logic [NUM_CPUS-1:0]            irq_o
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign irq_o[c] = |(stat_i & en_i[c]);
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_CPUS       = 2,
  parameter int SYNC_STAGES    = 2,
  parameter bit REVERSED_ORDER = 1'b0,
  parameter int ADDR_W         = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [31:0]         gpio_in,
  output logic [31:0]         gpio_out,
  output logic [31:0]         gpio_oe,
  output logic [NUM_CPUS-1:0] cpu_irq
);
  localparam int CPU_IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

  logic [LINES-1:0]   dir_q, dout_q, stat_q;
  logic [LINES-1:0]   line_evt, level_s, wr_l, clr_l;
  logic [2*LINES-1:0] mode_q, mode_pair, mode_d;
  logic [NUM_CPUS-1:0][LINES-1:0] en_q;

  logic hit_dir, hit_data, hit_stat, hit_mlo, hit_mhi, hit_cpu;
  logic [ADDR_W-1:0]    cpu_off;
  logic [CPU_IDX_W-1:0] cpu_sel;

  // Address decode
  assign hit_dir  = bus_addr == ADDR_W'(OFS_DIR);
  assign hit_data = bus_addr == ADDR_W'(OFS_DATA);
  assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
  assign hit_mlo  = bus_addr == ADDR_W'(OFS_MODE_LO);
  assign hit_mhi  = bus_addr == ADDR_W'(OFS_MODE_HI);
  assign cpu_off  = bus_addr - ADDR_W'(OFS_CPU_BASE);
  assign hit_cpu  = (bus_addr >= ADDR_W'(OFS_CPU_BASE)) && (cpu_off[1:0] == 2'b00) &&
                    (int'(cpu_off >> 2) < NUM_CPUS);
  assign cpu_sel  = CPU_IDX_W'(cpu_off >> 2);

  assign wr_l  = swz_flags(bus_wdata, REVERSED_ORDER);
  assign clr_l = (bus_we && hit_stat) ? wr_l : '0;

  always_comb begin
    mode_pair = swz_mode(mode_q, REVERSED_ORDER);
    mode_d    = mode_q;
    if (bus_we && hit_mlo) mode_d = swz_mode({mode_pair[63:32], bus_wdata}, REVERSED_ORDER);
    if (bus_we && hit_mhi) mode_d = swz_mode({bus_wdata, mode_pair[31:0]}, REVERSED_ORDER);
  end

  gpio_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (gpio_in),
    .mode_i  (mode_q),
    .level_o (level_s),
    .event_o (line_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      stat_q <= '0;
      mode_q <= '0;
      en_q   <= '0;
    end else begin
      if (bus_we && hit_dir)  dir_q  <= wr_l;
      if (bus_we && hit_data) dout_q <= wr_l;
      mode_q <= mode_d;
      stat_q <= (stat_q & ~clr_l) | line_evt;
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (bus_we && hit_cpu && int'(cpu_sel) == c) en_q[c] <= wr_l;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_dir)       bus_rdata = swz_flags(dir_q, REVERSED_ORDER);
    else if (hit_data) bus_rdata = swz_flags((dir_q & dout_q) | (~dir_q & level_s), REVERSED_ORDER);
    else if (hit_stat) bus_rdata = swz_flags(stat_q, REVERSED_ORDER);
    else if (hit_mlo)  bus_rdata = mode_pair[31:0];
    else if (hit_mhi)  bus_rdata = mode_pair[63:32];
    else if (hit_cpu)  bus_rdata = swz_flags(en_q[cpu_sel], REVERSED_ORDER);
  end

  gpio_irq_route #(.NUM_CPUS(NUM_CPUS)) u_route (
    .stat_i (stat_q),
    .en_i   (en_q),
    .irq_o  (cpu_irq)
  );

  assign gpio_out = dout_q;
  assign gpio_oe  = dir_q;

  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_stat) |=> ((stat_q & $past(wr_l & ~line_evt)) == '0)); // R6
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(line_evt) & ~stat_q) == '0)); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(line_evt)) == '0)); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(gpio_oe)); // R2
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> (cpu_irq == '0)); // R9
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
  localparam int NC = 2;
  localparam logic [7:0] A_DIR = 8'h08, A_DATA = 8'h0C, A_STAT = 8'h10,
                         A_MLO = 8'h14, A_MHI = 8'h18, A_M0 = 8'h40, A_M1 = 8'h44;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd_n = '0, wd_r = '0, pins = '0;
  logic [31:0] rd_n, rd_r, out_n, out_r, oe_n, oe_r;
  logic [NC-1:0] irq_n, irq_r;
  int checks = 0, fails = 0;

  always #10ns clk = ~clk;

  gpio_edge_ctrl #(.NUM_CPUS(NC), .REVERSED_ORDER(1'b0)) i_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wd_n),
    .bus_rdata(rd_n), .gpio_in(pins), .gpio_out(out_n), .gpio_oe(oe_n), .cpu_irq(irq_n));

  gpio_edge_ctrl #(.NUM_CPUS(NC), .REVERSED_ORDER(1'b1)) i_gpio_edge_ctrl_rev (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wd_r),
    .bus_rdata(rd_r), .gpio_in(pins), .gpio_out(out_r), .gpio_oe(oe_r), .cpu_irq(irq_r));

  function automatic logic [31:0] fl(input logic [31:0] v, input bit rev);
    logic [31:0] r;
    r = '0;
    for (int l = 0; l < 32; l++) r[rev ? l : 8*(3 - l/8) + l%8] = v[l];
    return r;
  endfunction

  function automatic logic [63:0] mp(input logic [63:0] v, input bit rev);
    logic [63:0] r;
    r = '0;
    for (int l = 0; l < 32; l++) r[2*(rev ? l : 8*((l/8) ^ 1) + l%8) +: 2] = v[2*l +: 2];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] dn, input logic [31:0] dr);
    @(negedge clk);
    we = 1'b1; addr = a; wd_n = dn; wd_r = dr;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr_fl(input logic [7:0] a, input logic [31:0] v);
    wr(a, fl(v, 1'b0), fl(v, 1'b1));
  endtask

  task automatic wr_mode(input logic [63:0] v);
    logic [63:0] pn, pr;
    pn = mp(v, 1'b0); pr = mp(v, 1'b1);
    wr(A_MLO, pn[31:0], pr[31:0]);
    wr(A_MHI, pn[63:32], pr[63:32]);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] qn, output logic [31:0] qr);
    @(negedge clk);
    addr = a;
    #1ns;
    qn = rd_n; qr = rd_r;
  endtask

  task automatic chk_fl(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] qn, qr;
    rd(a, qn, qr);
    chk({tag, " normal"}, qn, fl(exp, 1'b0));
    chk({tag, " reversed"}, qr, fl(exp, 1'b1));
  endtask

  task automatic chk_raw(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] qn, qr;
    rd(a, qn, qr);
    chk({tag, " normal"}, qn, exp);
    chk({tag, " reversed"}, qr, exp);
  endtask

  task automatic chk_mode(input string tag, input logic [63:0] v);
    logic [31:0] qn, qr;
    logic [63:0] pn, pr;
    pn = mp(v, 1'b0); pr = mp(v, 1'b1);
    rd(A_MLO, qn, qr);
    chk({tag, " lo normal"}, qn, pn[31:0]);
    chk({tag, " lo reversed"}, qr, pr[31:0]);
    rd(A_MHI, qn, qr);
    chk({tag, " hi normal"}, qn, pn[63:32]);
    chk({tag, " hi reversed"}, qr, pr[63:32]);
  endtask

  task automatic chk_irq(input string tag, input logic [NC-1:0] exp);
    chk({tag, " normal"}, 32'(irq_n), 32'(exp));
    chk({tag, " reversed"}, 32'(irq_r), 32'(exp));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #4ms;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d, o, e;
    logic [63:0] mv;
    logic [1:0]  mc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_fl("R1 dir", A_DIR, '0);
    chk_fl("R1 data", A_DATA, '0);
    chk_fl("R1 stat", A_STAT, '0);
    chk_fl("R1 mask0", A_M0, '0);
    chk_fl("R1 mask1", A_M1, '0);
    chk_mode("R1 mode", '0);
    chk("R1 oe", oe_n | oe_r, '0);
    chk("R1 out", out_n | out_r, '0);
    chk_irq("R1 irq", '0);

    // R2 and R3: direction and output sweep
    for (int k = 0; k < 32; k++) begin
      d = 32'h1 << k;
      o = 32'hFFFF_FFFF << k;
      wr_fl(A_DIR, d);
      wr_fl(A_DATA, o);
      @(negedge clk);
      chk("R2 oe normal", oe_n, d);
      chk("R2 oe reversed", oe_r, d);
      chk("R2 out normal", out_n, o);
      chk("R2 out reversed", out_r, o);
      chk_fl("R2 dir readback", A_DIR, d);
      chk_fl("R3 data readback", A_DATA, d);
    end

    // R3: mixed readback
    d = 32'h0F0F_00FF; o = 32'h3C3C_A5A5;
    wr_fl(A_DIR, d);
    wr_fl(A_DATA, o);
    @(negedge clk) pins = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk_fl("R3 mixed data", A_DATA, (d & o) | (~d & pins));
    wr_fl(A_DIR, '0);
    wr_fl(A_DATA, '0);
    @(negedge clk) pins = '0;
    repeat (4) @(negedge clk);
    chk_fl("R4 no event with mode off", A_STAT, '0);

    // R10: unmapped offsets
    wr(8'h00, '1, '1);
    wr(8'h04, '1, '1);
    wr(8'h1C, '1, '1);
    wr(8'h3C, '1, '1);
    wr(8'h48, '1, '1);
    wr(8'h41, '1, '1);
    chk_raw("R10 read 0x00", 8'h00, '0);
    chk_raw("R10 read 0x04", 8'h04, '0);
    chk_raw("R10 read 0x1C", 8'h1C, '0);
    chk_raw("R10 read 0x48", 8'h48, '0);
    chk_fl("R10 dir untouched", A_DIR, '0);
    chk_fl("R10 mask0 untouched", A_M0, '0);
    chk_fl("R10 mask1 untouched", A_M1, '0);
    chk_mode("R10 mode untouched", '0);

    // R4, R5, R6, R9: every line, every mode code
    for (int L = 0; L < 32; L++) begin
      for (int m = 0; m < 4; m++) begin
        mc = 2'(m);
        mv = 64'(mc) << (2*L);
        wr_mode(mv);
        chk_mode("R5 mode layout", mv);
        wr_fl(A_M0, 32'h1 << L);
        wr_fl(A_M1, ~(32'h1 << L));
        chk_fl("R9 mask readback", A_M1, ~(32'h1 << L));
        @(negedge clk) pins[L] = 1'b1;
        repeat (4) @(negedge clk);
        e = mc[1] ? (32'h1 << L) : '0;
        chk_fl("R4 rising", A_STAT, e);
        chk_irq("R9 route rising", {1'b0, mc[1]});
        wr_fl(A_STAT, 32'h1 << L);
        chk_fl("R6 clear", A_STAT, '0);
        @(negedge clk) pins[L] = 1'b0;
        repeat (4) @(negedge clk);
        e = mc[0] ? (32'h1 << L) : '0;
        chk_fl("R4 falling", A_STAT, e);
        chk_irq("R9 route falling", {1'b0, mc[0]});
        wr_fl(A_STAT, 32'h1 << L);
      end
    end

    // R6: writing zero keeps a flag
    wr_mode(64'h3 << 10);
    wr_fl(A_M0, '1);
    wr_fl(A_M1, '0);
    @(negedge clk) pins[5] = 1'b1;
    repeat (4) @(negedge clk);
    wr_fl(A_STAT, '0);
    chk_fl("R6 write zero keeps", A_STAT, 32'h20);
    wr_fl(A_STAT, 32'h40);
    chk_fl("R6 other bit keeps", A_STAT, 32'h20);
    chk_irq("R9 mask0 only", 2'b01);
    wr_fl(A_STAT, 32'h20);
    chk_irq("R9 idle", 2'b00);

    // R8: latency of three clock edges
    @(negedge clk) pins[5] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_irq("R8 before third edge", 2'b00);
    @(negedge clk);
    chk_irq("R8 at third edge", 2'b01);
    wr_fl(A_STAT, 32'h20);
    chk_fl("R6 cleared after R8", A_STAT, '0);

    // R7: event and clear in the same cycle
    @(negedge clk) pins[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = A_STAT; wd_n = '1; wd_r = '1;
    @(negedge clk);
    we = 1'b0;
    chk_fl("R7 event wins", A_STAT, 32'h20);
    wr_fl(A_STAT, '1);
    chk_fl("R7 later clear", A_STAT, '0);

    summary();
  end
endmodule